// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line-Idle Flag

This block receives asynchronous serial frames on one line and hands each byte to a consumer through a single holding register. A baud-rate strobe pulses once per oversampling interval (sixteen per bit by default). A falling edge on the synchronised line opens a candidate start bit. A line that returns high on the very next strobe is treated as noise. A start bit whose mid-bit vote comes out high is rejected as well. A start bit that passes leads to eight data bits, received least significant first, followed by one stop bit.

The idle flag tells software whether the line is quiet. It drops on the strobe that sees the start edge. After a rejected start it comes back exactly one eighth of a bit later. After a completed frame it comes back at the stop-bit decision. A second false start right behind the first is rejected in the same way, so the flag can never stay low while the line is quiet. There are two enables. The serial enable resets the frame machine and the ready flag. The receive enable gates reception and is also the only control that clears the overrun flag.

Top module: `serial_rx_idle`

## Requirements
- R1: After reset, idle_o is 1, and ready_o, overrun_o, frame_err_o and data_o are all 0.
- R2: idle_o goes to 0 on the first strobe that sees the line low after it was high. It stays 0 for the whole frame and returns to 1 on the strobe that decides the stop bit, which is strobe 9 of the stop bit when the start edge is counted as strobe 0 of the start bit.
- R3: If the line is high again on the strobe after the start edge (a low pulse shorter than 1/16 bit), the start is dropped. idle_o returns to 1 on the second strobe after that one, OVS/8 strobes later, and no byte is delivered.
- R4: A second false start that begins within one bit time of the first is rejected the same way. idle_o then reads 1, and a valid frame that follows is received intact.
- R5: A start bit whose majority vote at strobes 7, 8 and 9 reads high is rejected. idle_o returns to 1 two strobes after the vote, and no byte is delivered.
- R6: Data bits arrive least significant bit first. Each bit takes the 2-of-3 majority of the samples at strobes 7, 8 and 9 of that bit, so a single wrong sample does not change the byte.
- R7: ready_o rises, with data_o valid, when a frame completes and the holding register is free. A one-cycle rd_i pulse clears ready_o.
- R8: frame_err_o is loaded together with each byte. It is 1 if that frame's stop bit was sampled low and 0 if it was sampled high.
- R9: If a frame completes while ready_o is 1 and rd_i is not asserted, overrun_o is set and data_o keeps the older byte. While overrun_o is 1, every further completed frame is discarded.
- R10: overrun_o clears only through reset or when rx_en_i is 0. Setting ser_en_i to 0 leaves overrun_o unchanged.
- R11: One clock after ser_en_i is 0, idle_o is 1, any frame in progress is abandoned and ready_o is 0.
- R12: While rx_en_i or ser_en_i is 0, no frame is started and no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, asynchronous to clk |
| tick_i | input | 1 | Oversampling strobe, one pulse per 1/OVS bit |
| ser_en_i | input | 1 | Serial enable. When 0, resets the frame machine and ready_o |
| rx_en_i | input | 1 | Receive enable. When 0, clears overrun_o and stops reception |
| rd_i | input | 1 | Read strobe that consumes the held byte |
| data_o | output | DATA_W | Held byte |
| ready_o | output | 1 | A byte is waiting in the holding register |
| idle_o | output | 1 | Line quiet; no start being qualified and no frame in progress |
| overrun_o | output | 1 | A byte arrived while the holding register was full |
| frame_err_o | output | 1 | The held byte had a low stop bit |

## Verification
The bench builds the block with the default values: OVS of 16, DATA_W of 8 and two synchroniser stages. It pulses the strobe every fourth clock. With that spacing, a line change made just after one strobe has passed the synchroniser before the next, so every idle-flag edge, vote sample and false-start recovery can be checked on an exact strobe. Because the one-eighth-bit guard is only two strobes long at this setting, two false starts can be placed inside a single bit time. A single sample can be corrupted on exactly the first vote strobe.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_QUAL,
      ST_DATA,
      ST_STOP,
      ST_GUARD
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote (
   input  logic clk,
   input  logic rst_n,
   input  logic grab_i,
   input  logic s_i,
   output logic maj_o
);
   import serial_rx_pkg::*;

   logic [1:0] hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hist <= 2'b11;
      else if (grab_i) hist <= {hist[0], s_i};
   end

   // third sample is the live one on the deciding strobe
   assign maj_o = maj3(hist[1], hist[0], s_i);

endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer #(
   parameter int OVS    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              rx_s_i,
   output logic              idle_o,
   output logic              done_o,
   output logic [DATA_W-1:0] frame_o,
   output logic              stop_ok_o
);
   import serial_rx_pkg::*;

   localparam int PH_W  = $clog2(OVS);
   localparam int MID   = OVS / 2;
   localparam int GUARD = OVS / 8;
   localparam int GC_W  = (GUARD > 1) ? $clog2(GUARD) : 1;
   localparam int BC_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   rx_state_e         state;
   logic [PH_W-1:0]   phase;
   logic [BC_W-1:0]   bitc;
   logic [GC_W-1:0]   gcnt;
   logic              last;
   logic [DATA_W-1:0] shreg;
   logic              maj;
   logic              grab;
   logic              decide_pt;
   logic              in_frame;

   assign in_frame  = (state == ST_QUAL) || (state == ST_DATA) || (state == ST_STOP);
   assign decide_pt = (phase == PH_W'(MID + 1));
   assign grab      = tick_i && in_frame &&
                      ((phase == PH_W'(MID - 1)) || (phase == PH_W'(MID)));

   serial_rx_vote u_vote (
      .clk    (clk),
      .rst_n  (rst_n),
      .grab_i (grab),
      .s_i    (rx_s_i),
      .maj_o  (maj)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         phase <= '0;
         bitc  <= '0;
         gcnt  <= '0;
         last  <= 1'b1;
         shreg <= '0;
      end else begin
         if (tick_i) last <= rx_s_i;
         if (!run_i) begin
            state <= ST_IDLE;
            phase <= '0;
            bitc  <= '0;
            gcnt  <= '0;
         end else if (tick_i) begin
            case (state)
               ST_IDLE: begin
                  if (!rx_s_i && last) begin
                     state <= ST_QUAL;
                     phase <= PH_W'(1);
                  end
               end
               ST_QUAL: begin
                  phase <= phase + 1'b1;
                  if (phase == PH_W'(1) && rx_s_i) begin
                     state <= ST_GUARD;
                     gcnt  <= '0;
                  end else if (decide_pt) begin
                     if (maj) begin
                        state <= ST_GUARD;
                        gcnt  <= '0;
                     end else begin
                        state <= ST_DATA;
                        bitc  <= '0;
                     end
                  end
               end
               ST_DATA: begin
                  phase <= phase + 1'b1;
                  if (decide_pt) begin
                     shreg <= {maj, shreg[DATA_W-1:1]};
                     if (bitc == BC_W'(DATA_W - 1)) state <= ST_STOP;
                     else                           bitc  <= bitc + 1'b1;
                  end
               end
               ST_STOP: begin
                  phase <= phase + 1'b1;
                  if (decide_pt) state <= ST_IDLE;
               end
               ST_GUARD: begin
                  if (gcnt == GC_W'(GUARD - 1)) state <= ST_IDLE;
                  else                          gcnt  <= gcnt + 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign idle_o    = (state == ST_IDLE);
   assign done_o    = run_i && tick_i && (state == ST_STOP) && decide_pt;
   assign frame_o   = shreg;
   assign stop_ok_o = maj;

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en_i,
   input  logic              rx_en_i,
   input  logic              rd_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] frame_i,
   input  logic              stop_ok_i,
   output logic [DATA_W-1:0] data_o,
   output logic              ready_o,
   output logic              overrun_o,
   output logic              frame_err_o
);

   logic blocked;
   logic load;

   assign blocked = ready_o && !rd_i;
   assign load    = done_i && !overrun_o && !blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o      <= '0;
         ready_o     <= 1'b0;
         overrun_o   <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         if (!rx_en_i)               overrun_o <= 1'b0;
         else if (done_i && blocked) overrun_o <= 1'b1;

         if (!ser_en_i) begin
            ready_o <= 1'b0;
         end else if (load) begin
            ready_o     <= 1'b1;
            data_o      <= frame_i;
            frame_err_o <= !stop_ok_i;
         end else if (rd_i) begin
            ready_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/serial_rx_idle.sv
module serial_rx_idle #(
   parameter int OVS         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic              ser_en_i,
   input  logic              rx_en_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              ready_o,
   output logic              idle_o,
   output logic              overrun_o,
   output logic              frame_err_o
);

   generate
      if (OVS < 16 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two no smaller than 16");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              run;
   logic              done;
   logic [DATA_W-1:0] frame;
   logic              stop_ok;

   assign run = ser_en_i && rx_en_i;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   serial_rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run),
      .tick_i    (tick_i),
      .rx_s_i    (rx_s),
      .idle_o    (idle_o),
      .done_o    (done),
      .frame_o   (frame),
      .stop_ok_o (stop_ok)
   );

   serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .ser_en_i    (ser_en_i),
      .rx_en_i     (rx_en_i),
      .rd_i        (rd_i),
      .done_i      (done),
      .frame_i     (frame),
      .stop_ok_i   (stop_ok),
      .data_o      (data_o),
      .ready_o     (ready_o),
      .overrun_o   (overrun_o),
      .frame_err_o (frame_err_o)
   );

endmodule

// File: rtl/serial_rx_idle_chk.sv
module serial_rx_idle_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_en_i,
   input logic              rx_en_i,
   input logic [DATA_W-1:0] data_o,
   input logic              ready_o,
   input logic              idle_o,
   input logic              overrun_o
);

   // R11: serial enable off forces the idle flag high on the next clock
   a_r11_ser_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_en_i |=> idle_o);

   // R10: with the receive enable on, overrun never drops
   a_r10_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && rx_en_i) |=> overrun_o);

   // R10: receive enable off clears overrun
   a_r10_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en_i |=> !overrun_o);

   // R9: the held byte is frozen while overrun is flagged
   a_r9_ovr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_o |=> $stable(data_o));

   // R7: a byte only appears at the end of a frame, when the line is idle
   a_r7_ready_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> idle_o);

   // R12: leaving idle needs both enables
   a_r12_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_o) |-> $past(ser_en_i && rx_en_i));

endmodule

bind serial_rx_idle serial_rx_idle_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ser_en_i  (ser_en_i),
   .rx_en_i   (rx_en_i),
   .data_o    (data_o),
   .ready_o   (ready_o),
   .idle_o    (idle_o),
   .overrun_o (overrun_o)
);

// File: tb/serial_rx_idle_tb.sv
module serial_rx_idle_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b0;
   logic       ser_en = 1'b0;
   logic       rx_en = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] data;
   logic       ready, idle, overrun, ferr;

   int n_chk = 0;
   int n_bad = 0;
   bit auto_rd = 1'b1;
   bit ended = 1'b0;
   logic [8:0] exp_q[$];

   always #5 clk = ~clk;

   serial_rx_idle u_dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
      .ser_en_i(ser_en), .rx_en_i(rx_en), .rd_i(rd),
      .data_o(data), .ready_o(ready), .idle_o(idle),
      .overrun_o(overrun), .frame_err_o(ferr)
   );

   // oversampling strobe: one clock high out of every four
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // returns just after the n-th strobe edge
   task automatic ticks(input int n);
      repeat (n) begin
         @(posedge clk);
         while (!tick) @(posedge clk);
      end
      #1;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // driver: pushes the expected item, then shapes the frame on the line
   task automatic send_frame(input logic [7:0] b, input bit stop_hi, input bit push,
                             input bit watch, input int flip);
      if (push) exp_q.push_back({~stop_hi, b});
      rx = 1'b0;
      ticks(1);
      if (watch) chk("R2 idle low at start edge", idle, 0);
      ticks(15);
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         if (i == flip) begin
            ticks(7);
            rx = ~b[i];
            ticks(1);
            rx = b[i];
            ticks(8);
         end else begin
            ticks(16);
         end
      end
      rx = stop_hi;
      ticks(9);
      if (watch) chk("R2 idle low before stop decision", idle, 0);
      ticks(1);
      if (watch) chk("R2 idle high at stop decision", idle, 1);
      ticks(6);
      rx = 1'b1;
      ticks(4);
   endtask

   // monitor: pops and compares every delivered byte
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rd && ready) begin
            if (exp_q.size() == 0) begin
               chk("R7 unexpected byte", {23'd0, ferr, data}, 32'h1ff);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk("R6 R8 byte and frame error", {23'd0, ferr, data}, {23'd0, e});
            end
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 idle", idle, 1);
      chk("R1 ready", ready, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 frame_err", ferr, 0);
      chk("R1 data", data, 0);
      rst_n = 1'b1;
      ser_en = 1'b1;
      rx_en = 1'b1;
      ticks(4);

      // R2 R6 R7: plain frames
      send_frame(8'hA5, 1'b1, 1'b1, 1'b1, -1);
      chk("R7 ready cleared by read", ready, 0);
      send_frame(8'h3C, 1'b1, 1'b1, 1'b1, -1);
      send_frame(8'h01, 1'b1, 1'b1, 1'b1, -1);

      // R6: one corrupted sample per chosen bit
      send_frame(8'h96, 1'b1, 1'b1, 1'b1, 2);
      send_frame(8'h69, 1'b1, 1'b1, 1'b1, 7);

      // R8: low stop bit, then a clean one
      send_frame(8'h5A, 1'b0, 1'b1, 1'b1, -1);
      send_frame(8'hC3, 1'b1, 1'b1, 1'b1, -1);

      // R3: single-strobe glitch
      rx = 1'b0;
      ticks(1);
      chk("R3 idle low on glitch edge", idle, 0);
      rx = 1'b1;
      ticks(1);
      chk("R3 idle low when glitch seen", idle, 0);
      ticks(1);
      chk("R3 idle low during guard", idle, 0);
      ticks(1);
      chk("R3 idle high one eighth bit later", idle, 1);
      // R4: second glitch within the same bit time
      rx = 1'b0;
      ticks(1);
      chk("R4 idle low on second glitch", idle, 0);
      rx = 1'b1;
      ticks(3);
      chk("R4 idle high after second glitch", idle, 1);
      ticks(16);
      chk("R4 idle stays high", idle, 1);
      chk("R3 no byte from glitches", ready, 0);
      send_frame(8'hE7, 1'b1, 1'b1, 1'b1, -1);

      // R5: low for three strobes, vote reads high
      rx = 1'b0;
      ticks(3);
      rx = 1'b1;
      ticks(8);
      chk("R5 idle low until vote guard ends", idle, 0);
      ticks(1);
      chk("R5 idle high after rejected start", idle, 1);
      ticks(8);
      chk("R5 no byte", ready, 0);

      // R9: overrun and discard
      auto_rd = 1'b0;
      send_frame(8'h11, 1'b1, 1'b0, 1'b1, -1);
      chk("R7 ready set", ready, 1);
      send_frame(8'h22, 1'b1, 1'b0, 1'b1, -1);
      chk("R9 overrun set", overrun, 1);
      chk("R9 older byte kept", data, 8'h11);
      send_frame(8'h33, 1'b0, 1'b0, 1'b1, -1);
      chk("R9 byte discarded under overrun", data, 8'h11);
      chk("R9 frame_err untouched", ferr, 0);

      // R10 R11: serial enable off keeps overrun
      ser_en = 1'b0;
      ticks(2);
      chk("R10 overrun survives serial disable", overrun, 1);
      chk("R11 ready cleared", ready, 0);
      ser_en = 1'b1;
      ticks(2);
      chk("R10 overrun still set", overrun, 1);
      rx_en = 1'b0;
      @(posedge clk);
      #1;
      chk("R10 receive disable clears overrun", overrun, 0);

      // R12: frames ignored with receive off
      send_frame(8'h44, 1'b1, 1'b0, 1'b0, -1);
      chk("R12 no byte while disabled", ready, 0);
      chk("R12 idle while disabled", idle, 1);
      rx_en = 1'b1;
      auto_rd = 1'b1;
      ticks(4);

      // R11: abandon a frame mid-way
      rx = 1'b0;
      ticks(40);
      chk("R11 busy mid-frame", idle, 0);
      ser_en = 1'b0;
      @(posedge clk);
      #1;
      chk("R11 idle one clock after disable", idle, 1);
      rx = 1'b1;
      ticks(20);
      ser_en = 1'b1;
      ticks(200);
      chk("R11 nothing delivered from abandoned frame", ready, 0);

      send_frame(8'h7E, 1'b1, 1'b1, 1'b1, -1);
      ticks(20);
      chk("R7 all expected bytes delivered", exp_q.size(), 0);
      finish_run();
   end

endmodule